// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block sits between a byte-wide parallel bus and a small register model of a boot-block flash array. Software drives it with bus write cycles that carry command bytes. The controller turns those writes into program and block-erase jobs, and a write sequencer runs those jobs. The controller also decides what a bus read returns: array bytes, the status byte or the identifier bytes. Programming can only clear bits. Erase restores a whole block to 0xFF. Error flags stay set until software clears them.

The array is 2^ADDR_W bytes, which is 512 by default. It is split into seven erase blocks that keep the proportions of a 512 KB boot-block part at one byte per kilobyte. The top-boot map, in ascending address order, has:
- three 128-byte main blocks at 0–383;
- a 96-byte main block at 384–479;
- an 8-byte parameter block at 480–487;
- an 8-byte parameter block at 488–495;
- a 16-byte boot block at 496–511.

With TOP_BOOT=0 the map is mirrored. Program and erase latencies are modelled with cycle counters. The erase writes one byte per cycle, so the array maps onto a single-port block RAM.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write of 0x40 or 0x10 arms a program. The next bus write latches its address and data and starts programming that byte. A bus write is any clock cycle in which ce_n and we_n are both low.
- R2: Programming stores the old byte AND the new byte. A 1 in the data leaves the stored bit unchanged, and no error is flagged.
- R3: A write of 0x20 followed by 0xD0 sets every byte of the block that holds the 0xD0 write's address to 0xFF. Bytes outside that block are not touched. The block boundaries are the ones given above.
- R4: If any byte other than 0xD0 follows 0x20, status bits 5 and 4 are set, no erase runs, and reads return array data.
- R5: The status byte is laid out as follows:
  - bit 7: ready;
  - bit 6: erase suspended;
  - bit 5: erase error;
  - bit 4: program error;
  - bit 3: programming voltage low;
  - bits 2–0: always 0.

  While a job runs and is not suspended, bit 7 reads 0.
- R6: Once a program or erase command is accepted, every read returns the status byte until 0xFF is written. After 0xFF, reads return the array. A write of 0x70 selects status reads at any time.
- R7: Bits 5, 4 and 3 stay set through later commands and successful jobs. Only a write of 0x50 clears them.
- R8: When vpp_ok is low, a program request sets bits 4 and 3 and an erase request sets bits 5 and 3. In both cases the array is left unchanged.
- R9: A program or erase aimed at the boot block while boot_unlock is low sets bit 4 (program) or bit 5 (erase) and leaves the array unchanged. When boot_unlock is high, the job runs normally.
- R10: After a write of 0x90, reads return MFR_CODE (0xA7) when address bit 0 is 0. When address bit 0 is 1, reads return DEV_CODE_TOP (0x5C) in top-boot mode or DEV_CODE_BOT (0x5D) in bottom-boot mode.
- R11: While an erase runs, a write of 0xB0 suspends it. Status then reads 0xC0, and 0xFF allows array reads. A later write of 0xD0 resumes the erase, which then completes.
- R12: While pwd_n is low:
  - any running job is aborted;
  - the status flags clear;
  - dout_oe is held low.

  When pwd_n returns high, reads return the array.
- R13: After rst, reads return the array, the status byte is 0x80, and dout_oe is the value of (!ce_n && !oe_n) registered on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwd_n | input | 1 | Reset/power-down, active low |
| vpp_ok | input | 1 | Programming voltage is valid |
| boot_unlock | input | 1 | Allows program/erase of the boot block |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, valid one clock after the address |
| dout_oe | output | 1 | Registered output-drive enable |

## Verification
The block is tested with three kinds of data pattern.
- **AND rule:** Two programs to one byte, 0xA5 and then 0x3C, must read back 0x24. Writing the second value outright would give 0x3C, so this result shows old AND new rather than a plain overwrite.
- **Block boundaries:** Erases are aimed at the blocks on either side of the 383/384 and 479/480 edges. Marker bytes programmed just across each edge must survive the erase, which shows where each block starts and ends.
- **Error paths:** A wrong confirm byte, a low programming voltage and a locked boot block are each tried. Each leaves its own status pattern (0xB0, 0x98/0xA8, 0xA0/0x90) and must leave the array unchanged.

Suspend and power-down are each applied during a running erase. Array reads taken while the erase is suspended or after the abort must show untouched bytes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  typedef enum logic [2:0] {
    M_ARRAY, M_STATUS, M_ID, M_PSETUP, M_ESETUP
  } cui_mode_e;

  typedef enum logic [2:0] {
    W_IDLE, W_PWAIT, W_PREAD, W_PWRITE, W_EWAIT, W_EWALK
  } wsm_state_e;

endpackage

// File: rtl/flash_blkmap.sv
module flash_blkmap #(
  parameter int ADDR_W   = 9,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_boot,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last
);
  // block starts in units of 1/64 of the array
  localparam int U8 = 8 << (ADDR_W - 9);
  localparam int ST_T [8] = '{0, 16, 32, 48, 60, 61, 62, 64};
  localparam int ST_B [8] = '{0, 2, 3, 4, 16, 32, 48, 64};

  function automatic int start_of(int i);
    return TOP_BOOT ? ST_T[i] : ST_B[i];
  endfunction

  logic [6:1] ge;
  logic [2:0] idx;

  for (genvar g = 1; g < 7; g++) begin : g_cmp
    localparam int S = TOP_BOOT ? ST_T[g] : ST_B[g];
    assign ge[g] = ({1'b0, addr} >= (ADDR_W+1)'(S * U8));
  end

  always_comb begin
    idx = '0;
    for (int i = 1; i < 7; i++)
      if (ge[i]) idx = 3'(i);
  end

  always_comb begin
    base = '0;
    last = '0;
    for (int i = 0; i < 7; i++)
      if (idx == 3'(i)) begin
        base = ADDR_W'(start_of(i) * U8);
        last = ADDR_W'(start_of(i + 1) * U8 - 1);
      end
  end

  if (TOP_BOOT) begin : g_top
    assign is_boot = (idx == 3'd6);
  end else begin : g_bot
    assign is_boot = (idx == 3'd0);
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wd,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm import flash_cmd_pkg::*; #(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 4,
  parameter int ERASE_WAIT  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] blk_base,
  input  logic [ADDR_W-1:0] blk_last,
  input  logic [7:0]        mem_q,
  output logic              busy,
  output logic              suspended,
  output logic              owns_mem,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wd
);
  localparam int CMAX  = (PROG_CYCLES > ERASE_WAIT) ? PROG_CYCLES : ERASE_WAIT;
  localparam int CNT_W = $clog2(CMAX + 1);

  wsm_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] pa_q, walk_q, last_q;
  logic [7:0]        pd_q;
  logic              susp_q;
  logic              in_erase;

  assign in_erase = (st_q == W_EWAIT) || (st_q == W_EWALK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= W_IDLE;
      cnt_q  <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
      walk_q <= '0;
      last_q <= '0;
      susp_q <= 1'b0;
    end else begin
      if (in_erase && susp_req) susp_q <= 1'b1;
      else if (resume_req)      susp_q <= 1'b0;
      case (st_q)
        W_IDLE: begin
          susp_q <= 1'b0;
          if (start_prog) begin
            pa_q  <= tgt_addr;
            pd_q  <= prog_data;
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
            st_q  <= W_PWAIT;
          end else if (start_erase) begin
            walk_q <= blk_base;
            last_q <= blk_last;
            cnt_q  <= CNT_W'(ERASE_WAIT - 1);
            st_q   <= W_EWAIT;
          end
        end
        W_PWAIT: begin
          if (cnt_q == '0) st_q <= W_PREAD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        W_PREAD:  st_q <= W_PWRITE;
        W_PWRITE: st_q <= W_IDLE;
        W_EWAIT: if (!susp_q) begin
          if (cnt_q == '0) st_q <= W_EWALK;
          else             cnt_q <= cnt_q - 1'b1;
        end
        W_EWALK: if (!susp_q) begin
          if (walk_q == last_q) st_q <= W_IDLE;
          else                  walk_q <= walk_q + 1'b1;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != W_IDLE);
  assign suspended = susp_q;
  assign owns_mem  = busy && !susp_q;
  assign mem_addr  = in_erase ? walk_q : pa_q;
  assign mem_we    = (st_q == W_PWRITE) || ((st_q == W_EWALK) && !susp_q);
  assign mem_wd    = (st_q == W_PWRITE) ? (mem_q & pd_q) : 8'hFF;

  // R11
  susp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    susp_q |-> !mem_we);

  // R3
  erase_in_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && st_q == W_EWALK) |-> (walk_q <= last_q));
endmodule

// File: rtl/flash_cui.sv
module flash_cui import flash_cmd_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       tgt_boot,
  input  logic       vpp_ok,
  input  logic       boot_unlock,
  input  logic       busy,
  input  logic       suspended,
  output cui_mode_e  mode,
  output logic [7:0] status,
  output logic       start_prog,
  output logic       start_erase,
  output logic       susp_req,
  output logic       resume_req
);
  cui_mode_e  mode_q, mode_d;
  logic [2:0] err_q, err_d;   // {erase, program, vpp}
  logic       clr_cmd;
  logic       locked;

  assign locked = tgt_boot && !boot_unlock;

  always_comb begin
    mode_d      = mode_q;
    err_d       = err_q;
    clr_cmd     = 1'b0;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    susp_req    = 1'b0;
    resume_req  = 1'b0;
    if (wr) begin
      if (busy && !suspended) begin
        if (wdata == CMD_STATUS) mode_d = M_STATUS;
        susp_req = (wdata == CMD_SUSPEND);
      end else if (suspended) begin
        case (wdata)
          CMD_ARRAY:   mode_d = M_ARRAY;
          CMD_STATUS:  mode_d = M_STATUS;
          CMD_IDENT:   mode_d = M_ID;
          CMD_CLEAR:   clr_cmd = 1'b1;
          CMD_CONFIRM: begin resume_req = 1'b1; mode_d = M_STATUS; end
          default: ;
        endcase
      end else begin
        case (mode_q)
          M_PSETUP: begin
            mode_d = M_STATUS;
            if (!vpp_ok)     err_d = err_q | 3'b011;
            else if (locked) err_d = err_q | 3'b010;
            else             start_prog = 1'b1;
          end
          M_ESETUP: begin
            if (wdata != CMD_CONFIRM) begin
              err_d  = err_q | 3'b110;
              mode_d = M_ARRAY;
            end else begin
              mode_d = M_STATUS;
              if (!vpp_ok)     err_d = err_q | 3'b101;
              else if (locked) err_d = err_q | 3'b100;
              else             start_erase = 1'b1;
            end
          end
          default: begin
            case (wdata)
              CMD_ARRAY:              mode_d = M_ARRAY;
              CMD_STATUS:             mode_d = M_STATUS;
              CMD_CLEAR:              clr_cmd = 1'b1;
              CMD_IDENT:              mode_d = M_ID;
              CMD_PROG_A, CMD_PROG_B: mode_d = M_PSETUP;
              CMD_ERASE:              mode_d = M_ESETUP;
              default: ;
            endcase
          end
        endcase
      end
    end
    if (clr_cmd) err_d = 3'b000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_ARRAY;
      err_q  <= 3'b000;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode   = mode_q;
  assign status = {(!busy || suspended), suspended, err_q, 3'b000};

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q != 3'b000 && !clr_cmd) |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R1
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (start_prog || start_erase) |-> !busy);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import flash_cmd_pkg::*; #(
  parameter int         ADDR_W       = 9,
  parameter bit         TOP_BOOT     = 1'b1,
  parameter int         PROG_CYCLES  = 4,
  parameter int         ERASE_WAIT   = 16,
  parameter logic [7:0] MFR_CODE     = 8'hA7,
  parameter logic [7:0] DEV_CODE_TOP = 8'h5C,
  parameter logic [7:0] DEV_CODE_BOT = 8'h5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwd_n,
  input  logic              vpp_ok,
  input  logic              boot_unlock,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_CODE_TOP : DEV_CODE_BOT;

  logic              rst_all, wr;
  logic              bus_boot;
  logic [ADDR_W-1:0] bus_base, bus_last;
  cui_mode_e         mode;
  logic [7:0]        status;
  logic              start_prog, start_erase, susp_req, resume_req;
  logic              wsm_busy, wsm_susp, wsm_owns, mem_we;
  logic [ADDR_W-1:0] wsm_addr, mem_addr;
  logic [7:0]        mem_wd, mem_q;
  logic              oe_q, id_lsb_q;

  assign rst_all = rst || !pwd_n;
  assign wr      = !ce_n && !we_n;

  flash_blkmap #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) i_map (
    .addr(addr), .is_boot(bus_boot), .base(bus_base), .last(bus_last));

  flash_cui i_cui (
    .clk(clk), .rst(rst_all), .wr(wr), .wdata(din), .tgt_boot(bus_boot),
    .vpp_ok(vpp_ok), .boot_unlock(boot_unlock), .busy(wsm_busy),
    .suspended(wsm_susp), .mode(mode), .status(status),
    .start_prog(start_prog), .start_erase(start_erase),
    .susp_req(susp_req), .resume_req(resume_req));

  flash_wsm #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_WAIT(ERASE_WAIT)) i_wsm (
    .clk(clk), .rst(rst_all), .start_prog(start_prog), .start_erase(start_erase),
    .susp_req(susp_req), .resume_req(resume_req), .tgt_addr(addr),
    .prog_data(din), .blk_base(bus_base), .blk_last(bus_last), .mem_q(mem_q),
    .busy(wsm_busy), .suspended(wsm_susp), .owns_mem(wsm_owns),
    .mem_we(mem_we), .mem_addr(wsm_addr), .mem_wd(mem_wd));

  assign mem_addr = wsm_owns ? wsm_addr : addr;

  flash_array #(.ADDR_W(ADDR_W)) i_arr (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wd(mem_wd), .q(mem_q));

  always_ff @(posedge clk) begin
    if (rst_all) begin
      oe_q     <= 1'b0;
      id_lsb_q <= 1'b0;
    end else begin
      oe_q     <= !ce_n && !oe_n;
      id_lsb_q <= addr[0];
    end
  end

  always_comb begin
    case (mode)
      M_ARRAY: dout = mem_q;
      M_ID:    dout = id_lsb_q ? DEV_CODE : MFR_CODE;
      default: dout = status;
    endcase
  end
  assign dout_oe = oe_q;

  // R12
  pwd_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !pwd_n |=> (!wsm_busy && !dout_oe));

  // R9
  boot_lock_chk: assert property (@(posedge clk) disable iff (rst_all)
    ((start_prog || start_erase) && bus_boot) |-> boot_unlock);

  // R8
  vpp_gate_chk: assert property (@(posedge clk) disable iff (rst_all)
    (start_prog || start_erase) |-> vpp_ok);
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1, pwd_n = 1'b1, vpp_ok = 1'b1, boot_unlock = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;

  int checks = 0, errors = 0;
  logic rd_req = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .pwd_n(pwd_n), .vpp_ok(vpp_ok), .boot_unlock(boot_unlock),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the read result
  always begin
    @(posedge clk);
    if (rd_req) begin
      @(negedge clk);
      chk(dout, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bw(input logic [7:0] d, input logic [ADDR_W-1:0] a = '0);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    v = 8'h00;
    for (int i = 0; i < 3000 && !v[7]; i++) begin
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      v = dout;
      ce_n = 1'b1; oe_n = 1'b1;
    end
    if (!v[7]) begin
      checks++; errors++;
      $display("FAIL R5 ready timeout actual=%02h expected=80", v);
    end
  endtask

  task automatic do_erase(input logic [ADDR_W-1:0] a);
    bw(8'h20); bw(8'hD0, a); wait_ready();
  endtask

  task automatic do_prog(input logic [7:0] code, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bw(code); bw(d, a); wait_ready();
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk({7'd0, dout_oe}, 8'h00, "R13 oe after reset");
    bw(8'h70); rd_exp(0, 8'h80, "R13 status after reset");
    // R13 dout_oe follows strobes
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk({7'd0, dout_oe}, 8'h01, "R13 oe when enabled");
    ce_n = 1'b1; oe_n = 1'b1;

    // R3 / R5 / R6 erase block 0
    bw(8'h20); bw(8'hD0, 9'd5);
    rd_exp(5, 8'h00, "R5 busy status");
    wait_ready();
    rd_exp(5, 8'h80, "R6 status after erase");
    bw(8'hFF);
    rd_exp(5, 8'hFF, "R3 erased byte");
    rd_exp(127, 8'hFF, "R3 erased block end");

    // R1 / R2 program with both setup codes
    do_prog(8'h40, 9'd5, 8'hA5);
    bw(8'hFF); rd_exp(5, 8'hA5, "R1 program 0x40");
    do_prog(8'h10, 9'd5, 8'h3C);
    bw(8'hFF); rd_exp(5, 8'h24, "R2 and-only 0x10");

    // R3 block boundaries
    do_erase(9'd300); do_erase(9'd400); do_erase(9'd480);
    do_prog(8'h40, 9'd383, 8'h55);
    do_prog(8'h40, 9'd384, 8'h66);
    do_prog(8'h40, 9'd480, 8'h11);
    do_erase(9'd479);
    bw(8'hFF);
    rd_exp(383, 8'h55, "R3 below 96 block kept");
    rd_exp(384, 8'hFF, "R3 96 block start erased");
    rd_exp(479, 8'hFF, "R3 96 block end erased");
    rd_exp(480, 8'h11, "R3 parameter block kept");

    // R4 / R7 bad confirm and sticky errors
    bw(8'h20); bw(8'h33, 9'd5);
    rd_exp(5, 8'h24, "R4 array mode after bad confirm");
    bw(8'h70); rd_exp(5, 8'hB0, "R4 error bits");
    do_prog(8'h40, 9'd6, 8'hF0);
    rd_exp(6, 8'hB0, "R7 errors sticky");
    bw(8'h50); rd_exp(6, 8'h80, "R7 cleared");
    bw(8'hFF); rd_exp(6, 8'hF0, "R1 program after clear");

    // R8 programming voltage low
    vpp_ok = 1'b0;
    bw(8'h40); bw(8'h00, 9'd6);
    rd_exp(6, 8'h98, "R8 program vpp low");
    bw(8'h50);
    bw(8'h20); bw(8'hD0, 9'd6);
    rd_exp(6, 8'hA8, "R8 erase vpp low");
    bw(8'h50);
    vpp_ok = 1'b1;
    bw(8'hFF); rd_exp(6, 8'hF0, "R8 array unchanged");

    // R9 boot block lock
    bw(8'h20); bw(8'hD0, 9'd500);
    rd_exp(0, 8'hA0, "R9 locked erase");
    bw(8'h50);
    bw(8'h40); bw(8'h00, 9'd500);
    rd_exp(0, 8'h90, "R9 locked program");
    bw(8'h50);
    boot_unlock = 1'b1;
    do_erase(9'd500);
    do_prog(8'h40, 9'd500, 8'h12);
    boot_unlock = 1'b0;
    bw(8'hFF); rd_exp(500, 8'h12, "R9 unlocked program");

    // R10 identifier
    bw(8'h90);
    rd_exp(0, 8'hA7, "R10 manufacturer code");
    rd_exp(1, 8'h5C, "R10 device code");
    bw(8'hFF);

    // R11 suspend / resume
    bw(8'h20); bw(8'hD0, 9'd200);
    bw(8'hB0);
    rd_exp(0, 8'hC0, "R11 suspended status");
    bw(8'hFF);
    rd_exp(5, 8'h24, "R11 array read while suspended");
    bw(8'hD0);
    rd_exp(0, 8'h00, "R11 resumed busy");
    wait_ready();
    bw(8'hFF);
    rd_exp(200, 8'hFF, "R11 erase completes");
    rd_exp(128, 8'hFF, "R11 block start erased");

    // R12 power-down abort
    bw(8'h20); bw(8'hD0, 9'd300);
    @(negedge clk); pwd_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); chk({7'd0, dout_oe}, 8'h00, "R12 oe low in power-down");
    pwd_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    rd_exp(383, 8'h55, "R12 abort leaves array, array mode");
    bw(8'h70); rd_exp(0, 8'h80, "R12 status idle after abort");

    finish_run();
  end
endmodule